// File: doc/BRIEF.md
# External Bus Strobe Generator

This block derives the external memory bus timing for a classic 8-bit microcontroller from the oscillator clock. A machine cycle lasts 12 oscillator clocks and is split into two halves of six clocks. In each half the block can emit one address-latch pulse (`aleOut`, active high) followed by one code-read strobe (`psenN`, active low). It also drives the upper address byte (`hiAddr`) for the external bus.

The CPU core reports the kind of each machine cycle on `accKind` and holds it stable for the whole cycle. The four kinds are code fetch, external data access through a 16-bit pointer, external data access through an 8-bit register pointer, and table read from code space. The block leaves out strobes in a fixed pattern during data cycles. A one-bit configuration register silences the latch pulse when code runs from internal memory. The block also selects which byte drives the upper address lines.

All three outputs are registered, so each output lags its machine-cycle phase by one clock. The cycle phase counter starts again from 0 when reset is released.

Top module: `bus_strobe_gen`

## Requirements
- R1: In a code-fetch cycle with `extExec`=1, `aleOut` is high on clocks 1,2,7,8 and `psenN` is low on clocks 3,4,5,9,10,11 of the machine cycle. Clocks are numbered 0..11 and clock 0 starts when reset is released. Each latch pulse lasts 2 clocks and each read strobe lasts 3 clocks.
- R2: In a data cycle (`accKind` 1 = 16-bit pointer, 2 = 8-bit pointer), only the first-half latch pulse appears (clocks 1,2), and `psenN` stays high for the whole cycle.
- R3: `psenN` goes low only in code-fetch (`accKind`=0) or table-read (`accKind`=3) cycles with `extExec`=1. With `extExec`=0 it stays high in every cycle.
- R4: A write with `cfgWrEn`=1 and `cfgWrAddr`=8'h8E loads `cfgWrBit` into the latch-off bit. When that bit is 1 and `extExec`=0, `aleOut` is held high through code-fetch cycles. Table-read cycles still give both pulses, and data cycles still give the first pulse.
- R5: With `extExec`=1 the latch-off bit has no effect, and code-fetch cycles show the R1 pattern.
- R6: In a 16-bit pointer data cycle, `hiAddr` equals `ptrHi`.
- R7: In an 8-bit pointer data cycle, `hiAddr` equals `p2Latch`.
- R8: In code-fetch and table-read cycles, `hiAddr` equals `codeHi` when `extExec`=1 and equals `p2Latch` when `extExec`=0.
- R9: A write to any address other than 8'h8E leaves the latch-off bit unchanged.
- R10: While `rst` is high, `aleOut`=1, `psenN`=1, `hiAddr`=0 and the latch-off bit is cleared to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Asynchronous reset, active high |
| extExec | input | 1 | Code is running from external program memory |
| accKind | input | 2 | Machine-cycle kind: 0 fetch, 1 data 16-bit pointer, 2 data 8-bit pointer, 3 table read |
| ptrHi | input | 8 | Upper byte of the 16-bit data pointer |
| p2Latch | input | 8 | Contents of the port-2 output latch |
| codeHi | input | 8 | Upper byte of the code address |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrAddr | input | 8 | Configuration write address |
| cfgWrBit | input | 1 | Value written to the latch-off bit |
| aleOut | output | 1 | Address latch enable, active high |
| psenN | output | 1 | Code-read strobe, active low |
| hiAddr | output | 8 | Upper address byte |

## Verification
On every clock the assertions check the following:
- the width of each latch pulse and each read strobe;
- that a read strobe appears only in an external code or table cycle;
- that data cycles never produce a read strobe;
- the source that drives the upper address byte;
- the idle levels during reset.

Only the bench scenarios can show the rest, because it depends on state and sequence:
- the exact clock positions of the pulses within a machine cycle;
- the missing second-half pulse in data cycles;
- the effect of the configuration bit, which depends on an earlier register write;
- that an off-address write is ignored;
- that reset clears the bit.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_DATA16 = 2'd1,
    ACC_DATA8  = 2'd2,
    ACC_MOVC   = 2'd3
  } accKind_t;

  // Per-clock timing strobes from the phase sequencer to the datapath
  typedef struct packed {
    logic aleSlot;     // phase lies inside a latch pulse window
    logic psenSlot;    // phase lies inside a read strobe window
    logic secondHalf;  // phase lies in the second half of the machine cycle
  } strobe_t;

endpackage

// File: rtl/bus_strobe_ctrl.sv
module bus_strobe_ctrl
  import bus_strobe_pkg::*;
#(
  parameter int CYCLE_LEN = 12,
  parameter int ALE_LEN   = 2,
  parameter int PSEN_LEN  = 3
) (
  input  logic    clk,
  input  logic    rst,
  output strobe_t strobes
);

  localparam int PH_W = $clog2(CYCLE_LEN);
  localparam int HALF = CYCLE_LEN / 2;
  localparam logic [PH_W-1:0] LAST_C     = PH_W'(CYCLE_LEN - 1);
  localparam logic [PH_W-1:0] HALF_C     = PH_W'(HALF);
  localparam logic [PH_W-1:0] ALE_END_C  = PH_W'(ALE_LEN);
  localparam logic [PH_W-1:0] PSEN_END_C = PH_W'(ALE_LEN + PSEN_LEN);

  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] halfPos;
  logic            inSecond;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                 phase <= '0;
    else if (phase == LAST_C) phase <= '0;
    else                     phase <= phase + 1'b1;
  end

  always_comb begin
    inSecond = (phase >= HALF_C);
    halfPos  = inSecond ? (phase - HALF_C) : phase;
    strobes.secondHalf = inSecond;
    strobes.aleSlot    = (halfPos < ALE_END_C);
    strobes.psenSlot   = (halfPos >= ALE_END_C) && (halfPos < PSEN_END_C);
  end

endmodule

// File: rtl/bus_strobe_dp.sv
module bus_strobe_dp
  import bus_strobe_pkg::*;
#(
  parameter int          ADDR_W   = 8,
  parameter int          HI_W     = 8,
  parameter logic [7:0]  CFG_ADDR = 8'h8E
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobes,
  input  logic              extExec,
  input  accKind_t          kind,
  input  logic [HI_W-1:0]   ptrHi,
  input  logic [HI_W-1:0]   p2Latch,
  input  logic [HI_W-1:0]   codeHi,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgWrAddr,
  input  logic              cfgWrBit,
  output logic              aleOut,
  output logic              psenN,
  output logic [HI_W-1:0]   hiAddr
);

  localparam logic [ADDR_W-1:0] CFG_ADDR_C = ADDR_W'(CFG_ADDR);

  logic            aleOff;
  logic            dataCyc;
  logic            codeCyc;
  logic            aleHold;
  logic            aleNext;
  logic            psenNext;
  logic [HI_W-1:0] hiNext;

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                                    aleOff <= 1'b0;
    else if (cfgWrEn && cfgWrAddr == CFG_ADDR_C) aleOff <= cfgWrBit;
  end

  always_comb begin
    dataCyc  = (kind == ACC_DATA16) || (kind == ACC_DATA8);
    codeCyc  = (kind == ACC_FETCH) || (kind == ACC_MOVC);
    // Internal execution with the latch silenced: plain fetches leave the line high
    aleHold  = aleOff && !extExec && (kind == ACC_FETCH);
    aleNext  = aleHold ||
               (strobes.aleSlot && !(dataCyc && strobes.secondHalf));
    psenNext = !(strobes.psenSlot && extExec && codeCyc);
    if (kind == ACC_DATA16)   hiNext = ptrHi;
    else if (dataCyc)         hiNext = p2Latch;
    else if (extExec)         hiNext = codeHi;
    else                      hiNext = p2Latch;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      aleOut <= 1'b1;
      psenN  <= 1'b1;
      hiAddr <= '0;
    end else begin
      aleOut <= aleNext;
      psenN  <= psenNext;
      hiAddr <= hiNext;
    end
  end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bus_strobe_pkg::*;
#(
  parameter int         CYCLE_LEN = 12,
  parameter int         ALE_LEN   = 2,
  parameter int         PSEN_LEN  = 3,
  parameter int         ADDR_W    = 8,
  parameter int         HI_W      = 8,
  parameter logic [7:0] CFG_ADDR  = 8'h8E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              extExec,
  input  logic [1:0]        accKind,
  input  logic [HI_W-1:0]   ptrHi,
  input  logic [HI_W-1:0]   p2Latch,
  input  logic [HI_W-1:0]   codeHi,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgWrAddr,
  input  logic              cfgWrBit,
  output logic              aleOut,
  output logic              psenN,
  output logic [HI_W-1:0]   hiAddr
);

  strobe_t strobes;

  bus_strobe_ctrl #(
    .CYCLE_LEN(CYCLE_LEN),
    .ALE_LEN  (ALE_LEN),
    .PSEN_LEN (PSEN_LEN)
  ) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes)
  );

  bus_strobe_dp #(
    .ADDR_W  (ADDR_W),
    .HI_W    (HI_W),
    .CFG_ADDR(CFG_ADDR)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .extExec  (extExec),
    .kind     (accKind_t'(accKind)),
    .ptrHi    (ptrHi),
    .p2Latch  (p2Latch),
    .codeHi   (codeHi),
    .cfgWrEn  (cfgWrEn),
    .cfgWrAddr(cfgWrAddr),
    .cfgWrBit (cfgWrBit),
    .aleOut   (aleOut),
    .psenN    (psenN),
    .hiAddr   (hiAddr)
  );

endmodule

// File: rtl/bus_strobe_gen_chk.sv
module bus_strobe_gen_chk #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            extExec,
  input logic [1:0]      accKind,
  input logic [HI_W-1:0] ptrHi,
  input logic [HI_W-1:0] p2Latch,
  input logic [HI_W-1:0] codeHi,
  input logic            aleOut,
  input logic            psenN,
  input logic [HI_W-1:0] hiAddr
);

  // live goes high one clock after reset release, so $past never reaches into reset
  logic live;
  always_ff @(posedge clk or posedge rst) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  assert_reset_idle_R10: assert property (@(posedge clk)
    rst |=> (aleOut && psenN && hiAddr == '0));

  assert_ale_width_R1: assert property (@(posedge clk) disable iff (rst || !live)
    $rose(aleOut) |=> aleOut);

  assert_psen_width_R1: assert property (@(posedge clk) disable iff (rst || !live)
    $fell(psenN) |=> !psenN);

  assert_psen_source_R3: assert property (@(posedge clk) disable iff (rst || !live)
    !psenN |-> ($past(extExec) && ($past(accKind) == 2'd0 || $past(accKind) == 2'd3)));

  assert_data_no_psen_R2: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(accKind) == 2'd1 || $past(accKind) == 2'd2) |-> psenN);

  assert_hi_pointer_R6: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(accKind) == 2'd1) |-> (hiAddr == $past(ptrHi)));

  assert_hi_port_R7: assert property (@(posedge clk) disable iff (rst || !live)
    ($past(accKind) == 2'd2) |-> (hiAddr == $past(p2Latch)));

  assert_hi_code_R8: assert property (@(posedge clk) disable iff (rst || !live)
    (($past(accKind) == 2'd0 || $past(accKind) == 2'd3) && $past(extExec))
      |-> (hiAddr == $past(codeHi)));

endmodule

bind bus_strobe_gen bus_strobe_gen_chk #(.HI_W(HI_W)) chk (
  .clk    (clk),
  .rst    (rst),
  .extExec(extExec),
  .accKind(accKind),
  .ptrHi  (ptrHi),
  .p2Latch(p2Latch),
  .codeHi (codeHi),
  .aleOut (aleOut),
  .psenN  (psenN),
  .hiAddr (hiAddr)
);

// File: tb/bus_strobe_gen_test.sv
module bus_strobe_gen_test;

  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       extExec = 1'b0;
  logic [1:0] accKind = 2'd0;
  logic [7:0] ptrHi = 8'h00;
  logic [7:0] p2Latch = 8'h00;
  logic [7:0] codeHi = 8'h00;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrAddr = 8'h00;
  logic       cfgWrBit = 1'b0;
  logic       aleOut;
  logic       psenN;
  logic [7:0] hiAddr;

  int checks = 0;
  int errors = 0;

  typedef struct {
    bit        chk;
    bit [11:0] ale;
    bit [11:0] psen;
    bit [7:0]  hi;
    string     tag;
  } item_t;

  item_t expQ[$];

  bus_strobe_gen uut (
    .clk(clk), .rst(rst), .extExec(extExec), .accKind(accKind),
    .ptrHi(ptrHi), .p2Latch(p2Latch), .codeHi(codeHi),
    .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr), .cfgWrBit(cfgWrBit),
    .aleOut(aleOut), .psenN(psenN), .hiAddr(hiAddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench's own machine-cycle clock number
  int bph = 0;
  always @(posedge clk or posedge rst) begin
    if (rst) bph <= 0;
    else     bph <= (bph == 11) ? 0 : bph + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected masks derived from the requirements
  function automatic bit [11:0] aleMask(input logic [1:0] k, input bit ext, input bit off);
    if (off && !ext && k == 2'd0) return 12'hFFE;   // held high on clocks 1..11 (R4)
    if (k == 2'd1 || k == 2'd2)    return 12'h006;  // clocks 1,2 only (R2)
    return 12'h186;                                 // clocks 1,2,7,8 (R1)
  endfunction

  function automatic bit [11:0] psenMask(input logic [1:0] k, input bit ext);
    if (ext && (k == 2'd0 || k == 2'd3)) return 12'hE38; // clocks 3,4,5,9,10,11
    return 12'h000;
  endfunction

  bit offModel = 1'b0;

  task automatic runCycle(input logic [1:0] k, input bit ext, input logic [7:0] ph,
                          input logic [7:0] p2, input logic [7:0] ch, input string tag,
                          input bit doWr = 1'b0, input logic [7:0] wa = 8'h00,
                          input bit wb = 1'b0);
    item_t it;
    accKind = k; extExec = ext; ptrHi = ph; p2Latch = p2; codeHi = ch;
    it.chk  = !doWr;
    it.ale  = aleMask(k, ext, offModel);
    it.psen = psenMask(k, ext);
    if (k == 2'd1)      it.hi = ph;
    else if (k == 2'd2) it.hi = p2;
    else                it.hi = ext ? ch : p2;
    it.tag = tag;
    expQ.push_back(it);
    if (doWr) begin
      cfgWrEn = 1'b1; cfgWrAddr = wa; cfgWrBit = wb;
      if (wa == 8'h8E) offModel = wb;
    end
    @(negedge clk);
    cfgWrEn = 1'b0;
    repeat (11) @(negedge clk);
  endtask

  // Monitor: records the outputs over clocks 1..11 and compares them at clock 11
  bit [11:0] aleSeen, psenSeen;
  always @(negedge clk) begin
    if (!rst) begin
      if (bph == 0) begin
        aleSeen = '0; psenSeen = '0;
      end else begin
        aleSeen[bph]  = aleOut;
        psenSeen[bph] = !psenN;
        if (bph == 6 && expQ.size() > 0 && expQ[0].chk)
          check(hiAddr == expQ[0].hi, expQ[0].tag, "hiAddr",
                {4'h0, hiAddr}, {4'h0, expQ[0].hi});
        if (bph == 11 && expQ.size() > 0) begin
          item_t it;
          it = expQ.pop_front();
          if (it.chk) begin
            check(aleSeen == it.ale, it.tag, "ALE clock pattern", aleSeen, it.ale);
            check(psenSeen == it.psen, it.tag, "PSEN low pattern", psenSeen, it.psen);
          end
        end
      end
    end
  end

  task automatic resetCheck();
    check(aleOut == 1'b1, "R10", "ALE in reset", {11'h0, aleOut}, 12'h1);
    check(psenN == 1'b1, "R10", "PSEN in reset", {11'h0, psenN}, 12'h1);
    check(hiAddr == 8'h00, "R10", "hiAddr in reset", {4'h0, hiAddr}, 12'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    resetCheck();
    rst = 1'b0;
    runCycle(2'd0, 1'b1, 8'h00, 8'h3C, 8'h12, "R1 R8 ext fetch");
    runCycle(2'd1, 1'b1, 8'hA5, 8'h3C, 8'h12, "R2 R6 ext data16");
    runCycle(2'd2, 1'b1, 8'hA5, 8'h3C, 8'h12, "R2 R7 ext data8");
    runCycle(2'd3, 1'b1, 8'h00, 8'h77, 8'h4B, "R1 R8 ext table read");
    runCycle(2'd0, 1'b0, 8'h00, 8'h5A, 8'hEE, "R3 R8 int fetch");
    runCycle(2'd3, 1'b0, 8'h00, 8'h61, 8'hEE, "R3 R8 int table read");
    // Write to a neighbour address must be ignored
    runCycle(2'd0, 1'b0, 8'h00, 8'h5A, 8'hEE, "R9 write", 1'b1, 8'h8F, 1'b1);
    runCycle(2'd0, 1'b0, 8'h00, 8'h5A, 8'hEE, "R9 int fetch after off-address write");
    // Set the latch-off bit
    runCycle(2'd0, 1'b0, 8'h00, 8'h5A, 8'hEE, "R4 write", 1'b1, 8'h8E, 1'b1);
    runCycle(2'd0, 1'b0, 8'h00, 8'h5A, 8'hEE, "R4 int fetch held high");
    runCycle(2'd1, 1'b0, 8'hC3, 8'h5A, 8'hEE, "R4 R6 int data16 latch-off");
    runCycle(2'd2, 1'b0, 8'hC3, 8'h19, 8'hEE, "R4 R7 int data8 latch-off");
    runCycle(2'd3, 1'b0, 8'h00, 8'h5A, 8'hEE, "R4 int table read latch-off");
    runCycle(2'd0, 1'b1, 8'h00, 8'h5A, 8'h9D, "R5 ext fetch latch-off");
    runCycle(2'd0, 1'b0, 8'h00, 8'h2E, 8'hEE, "R4 int fetch held high again");
    // Reset in the middle of a run clears the latch-off bit
    rst = 1'b1;
    @(negedge clk);
    resetCheck();
    @(negedge clk);
    rst = 1'b0;
    offModel = 1'b0;
    runCycle(2'd0, 1'b0, 8'h00, 8'h44, 8'hEE, "R10 int fetch after reset");
    runCycle(2'd0, 1'b1, 8'h00, 8'h44, 8'h81, "R1 ext fetch after reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule